// File: doc/BRIEF.md
# Virtual ROM Window Controller

This block sits next to a soft processor's memory bus and watches two address streams: instruction fetches and data accesses. A 32 KiB read-only virtual region, from 0x10000 to 0x17FFF, holds data that is really kept in external serial flash. Only one 8 KiB page of that region can be held on chip at a time, in a cache window at 0x2000 to 0x3FFF. A fetch or load that lands on the resident page is redirected into the cache window in the same cycle. A fetch or load that lands on any other page raises a one-cycle exception request.

The processor's handler reads a fault register to learn which address missed and whether it was a fetch. It copies the page from flash into the cache RAM and writes the page number and a valid bit into the control register. It then clears the pending flag and retries the access. The block never moves data itself. It only checks the tag, raises the exception, remaps addresses and flags illegal writes.

Top module: `vrom_window_ctl`

## Requirements
- R1: After reset the valid bit is 0, the control register (select 0) and pending register (select 2) read 0, and `miss_exc` and `bus_err` are 0, so the first read access to the window always misses.
- R2: A fetch or load at an address A in 0x10000..0x17FFF, while valid is 1 and page number ((A-0x10000)>>13, 2 bits) equals the stored tag, is translated in the same cycle to 0x2000 + A[12:0] and raises no exception.
- R3: Any address outside 0x10000..0x17FFF (for example 0x0000, 0x1FFF, 0x3FFF, 0xFFFF, 0x18000) appears unchanged on the physical address output and never raises an exception.
- R4: A fetch or load in the window that does not hit, while no fault is pending, makes `miss_exc` high for exactly one cycle, in the cycle after the access, and sets the pending flag. The physical address output carries the virtual address unchanged during the missing access.
- R5: While the pending flag is set, further misses raise no exception and leave the fault register unchanged.
- R6: Writing 1 in bit 0 to select 2 clears the pending flag. Reading select 2 returns the pending flag in bit 0. A later miss faults again.
- R7: Select 0 is the control register: bit 0 is valid and bits 2:1 are the page tag. A write replaces both fields and a read returns them.
- R8: The fault register at select 1 holds the missing address in bits 16:0. Bit 31 is 1 for an instruction fetch and 0 for a data load. When a fetch and a load miss in the same cycle, the fetch is recorded.
- R9: A data write to the window is not translated, because the physical output equals the address. It pulses `bus_err` for one cycle in the next cycle and raises no exception. It leaves pending and the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Instruction fetch valid |
| if_addr | input | 17 | Fetch byte address |
| if_paddr | output | 17 | Translated fetch address |
| dm_req | input | 1 | Data access valid |
| dm_we | input | 1 | Data access is a write |
| dm_addr | input | 17 | Data byte address |
| dm_paddr | output | 17 | Translated data address |
| rg_wr | input | 1 | Register write strobe |
| rg_sel | input | 2 | Register select (0 control, 1 fault, 2 pending) |
| rg_wdata | input | 32 | Register write data |
| rg_rdata | output | 32 | Register read data for `rg_sel` |
| miss_exc | output | 1 | One-cycle miss exception request |
| bus_err | output | 1 | One-cycle error for a write to the window |

## Verification
The translation is tried with addresses on both sides of every window edge, including the last byte of the window and the first byte past it. It is also tried with addresses in the resident page and in each non-resident page. This separates range decoding from tag comparison. The fault path is tried with a fetch-only miss, a load-only miss, a simultaneous fetch and load miss, and a miss while a fault is pending. These cases show whether the fetch wins on a tie and whether the pending mask works. Writes to both a resident and a non-resident page show that write detection does not depend on the tag and does not disturb the control or pending state.

// File: rtl/vrom_pkg.sv
package vrom_pkg;
  // register select encodings on the control interface
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_FAULT = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // index of the snooped streams in the per-port arrays
  localparam int PORT_FETCH = 0;
  localparam int PORT_DATA  = 1;
  localparam int NPORTS     = 2;
endpackage

// File: rtl/vrom_region_dec.sv
module vrom_region_dec #(
  parameter int AW      = 17,
  parameter int VBASE   = 'h10000,
  parameter int PG_BITS = 13,
  parameter int NPAGE   = 4,
  parameter int CBASE   = 'h2000
) (
  input  logic [AW-1:0]              addr,
  input  logic                       res_valid,
  input  logic [$clog2(NPAGE)-1:0]   res_tag,
  output logic                       in_win,
  output logic                       hit,
  output logic [AW-1:0]              paddr
);
  localparam int TAG_W = $clog2(NPAGE);
  localparam int VSPAN = NPAGE << PG_BITS;
  localparam logic [AW:0]   VLO = (AW+1)'(VBASE);
  localparam logic [AW:0]   VHI = (AW+1)'(VBASE + VSPAN);
  localparam logic [AW-1:0] VB  = AW'(VBASE);
  localparam logic [AW-1:0] CB  = AW'(CBASE);

  logic [AW-1:0]    offset;
  logic [TAG_W-1:0] page;

  always_comb begin
    in_win = ({1'b0, addr} >= VLO) && ({1'b0, addr} < VHI);
    offset = addr - VB;
    page   = offset[PG_BITS +: TAG_W];
    hit    = in_win && res_valid && (page == res_tag);
    paddr  = hit ? (CB + AW'(addr[PG_BITS-1:0])) : addr;
  end
endmodule

// File: rtl/vrom_tag_regs.sv
module vrom_tag_regs #(
  parameter int NPAGE = 4,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wdata,
  output logic                     res_valid,
  output logic [$clog2(NPAGE)-1:0] res_tag
);
  localparam int TAG_W = $clog2(NPAGE);

  logic             valid_n;
  logic [TAG_W-1:0] tag_n;

  always_comb begin
    valid_n = res_valid;
    tag_n   = res_tag;
    if (wr_en) begin
      valid_n = wdata[0];
      tag_n   = wdata[TAG_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
    end else begin
      res_valid <= valid_n;
      res_tag   <= tag_n;
    end
  end
endmodule

// File: rtl/vrom_miss_ctl.sv
module vrom_miss_ctl #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_req,
  input  logic          f_in,
  input  logic          f_hit,
  input  logic [AW-1:0] f_addr,
  input  logic          d_req,
  input  logic          d_we,
  input  logic          d_in,
  input  logic          d_hit,
  input  logic [AW-1:0] d_addr,
  input  logic          pend_clr,
  output logic          exc,
  output logic          berr,
  output logic          pending,
  output logic [AW-1:0] fault_addr,
  output logic          fault_fetch
);
  logic          f_miss, d_miss, take;
  logic          exc_n, berr_n, pend_n, kind_n;
  logic [AW-1:0] fa_n;

  always_comb begin
    f_miss = f_req && f_in && !f_hit;
    d_miss = d_req && !d_we && d_in && !d_hit;
    take   = (f_miss || d_miss) && !pending;
    exc_n  = take;
    berr_n = d_req && d_we && d_in;
    pend_n = pending;
    fa_n   = fault_addr;
    kind_n = fault_fetch;
    if (take) begin
      pend_n = 1'b1;
      fa_n   = f_miss ? f_addr : d_addr;
      kind_n = f_miss;
    end else if (pend_clr) begin
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc         <= 1'b0;
      berr        <= 1'b0;
      pending     <= 1'b0;
      fault_addr  <= '0;
      fault_fetch <= 1'b0;
    end else begin
      exc         <= exc_n;
      berr        <= berr_n;
      pending     <= pend_n;
      fault_addr  <= fa_n;
      fault_fetch <= kind_n;
    end
  end

  // R4
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> !exc);
  // R4
  exc_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> pending);
  // R5
  pend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !exc);
  // R5
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !pend_clr) |=> $stable(fault_addr) && $stable(fault_fetch));
endmodule

// File: rtl/vrom_window_ctl.sv
module vrom_window_ctl
  import vrom_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 32,
  parameter int VBASE   = 'h10000,
  parameter int PG_BITS = 13,
  parameter int NPAGE   = 4,
  parameter int CBASE   = 'h2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  output logic [AW-1:0] if_paddr,
  input  logic          dm_req,
  input  logic          dm_we,
  input  logic [AW-1:0] dm_addr,
  output logic [AW-1:0] dm_paddr,
  input  logic          rg_wr,
  input  logic [1:0]    rg_sel,
  input  logic [DW-1:0] rg_wdata,
  output logic [DW-1:0] rg_rdata,
  output logic          miss_exc,
  output logic          bus_err
);
  localparam int TAG_W = $clog2(NPAGE);
  localparam logic [AW:0] CLO = (AW+1)'(CBASE);
  localparam logic [AW:0] CHI = (AW+1)'(CBASE + (1 << PG_BITS));

  logic             res_valid;
  logic [TAG_W-1:0] res_tag;
  logic [AW-1:0]    p_addr  [NPORTS];
  logic [AW-1:0]    p_paddr [NPORTS];
  logic             p_in    [NPORTS];
  logic             p_hit   [NPORTS];
  logic             pending, fault_fetch;
  logic [AW-1:0]    fault_addr;
  logic             ctrl_wr, pend_clr;

  assign p_addr[PORT_FETCH] = if_addr;
  assign p_addr[PORT_DATA]  = dm_addr;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    vrom_region_dec #(
      .AW(AW), .VBASE(VBASE), .PG_BITS(PG_BITS), .NPAGE(NPAGE), .CBASE(CBASE)
    ) u_dec (
      .addr      (p_addr[g]),
      .res_valid (res_valid),
      .res_tag   (res_tag),
      .in_win    (p_in[g]),
      .hit       (p_hit[g]),
      .paddr     (p_paddr[g])
    );
  end

  assign if_paddr = p_paddr[PORT_FETCH];
  // writes are never steered into the cache window
  assign dm_paddr = dm_we ? dm_addr : p_paddr[PORT_DATA];

  always_comb begin
    ctrl_wr  = rg_wr && (reg_sel_e'(rg_sel) == SEL_CTRL);
    pend_clr = rg_wr && (reg_sel_e'(rg_sel) == SEL_PEND) && rg_wdata[0];
  end

  vrom_tag_regs #(.NPAGE(NPAGE), .DW(DW)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wdata     (rg_wdata),
    .res_valid (res_valid),
    .res_tag   (res_tag)
  );

  vrom_miss_ctl #(.AW(AW)) u_miss (
    .clk         (clk),
    .rst_n       (rst_n),
    .f_req       (if_req),
    .f_in        (p_in[PORT_FETCH]),
    .f_hit       (p_hit[PORT_FETCH]),
    .f_addr      (if_addr),
    .d_req       (dm_req),
    .d_we        (dm_we),
    .d_in        (p_in[PORT_DATA]),
    .d_hit       (p_hit[PORT_DATA]),
    .d_addr      (dm_addr),
    .pend_clr    (pend_clr),
    .exc         (miss_exc),
    .berr        (bus_err),
    .pending     (pending),
    .fault_addr  (fault_addr),
    .fault_fetch (fault_fetch)
  );

  always_comb begin
    rg_rdata = '0;
    unique case (reg_sel_e'(rg_sel))
      SEL_CTRL:  rg_rdata[TAG_W:0] = {res_tag, res_valid};
      SEL_FAULT: begin
        rg_rdata[AW-1:0] = fault_addr;
        rg_rdata[DW-1]   = fault_fetch;
      end
      SEL_PEND:  rg_rdata[0] = pending;
      default:   rg_rdata = '0;
    endcase
  end

  // R2
  fetch_in_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && p_hit[PORT_FETCH]) |->
      ({1'b0, if_paddr} >= CLO) && ({1'b0, if_paddr} < CHI));
  // R3
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_in[PORT_FETCH] && !p_in[PORT_DATA]) |=> !miss_exc && !bus_err);
  // R9
  write_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req && dm_we && !if_req) |=> !miss_exc);
endmodule

// File: tb/vrom_window_ctl_tb.sv
`timescale 1ns/1ps
module vrom_window_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        if_req, dm_req, dm_we, rg_wr;
  logic [16:0] if_addr, dm_addr;
  logic [16:0] if_paddr, dm_paddr;
  logic [1:0]  rg_sel;
  logic [31:0] rg_wdata, rg_rdata;
  logic        miss_exc, bus_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vrom_window_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_paddr(if_paddr),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_paddr(dm_paddr),
    .rg_wr(rg_wr), .rg_sel(rg_sel), .rg_wdata(rg_wdata), .rg_rdata(rg_rdata),
    .miss_exc(miss_exc), .bus_err(bus_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected translation computed from the requirement text
  function automatic logic [16:0] xlate(input logic [16:0] a, input logic v, input logic [1:0] t);
    int off;
    if (a >= 17'h10000 && a <= 17'h17FFF) begin
      off = int'(a) - 'h10000;
      if (v && ((off >> 13) == int'(t))) return 17'h2000 + {4'b0, a[12:0]};
    end
    return a;
  endfunction

  task automatic rd(input logic [1:0] sel, input string req, input logic [31:0] exp);
    rg_sel = sel;
    #1;
    chk(req, rg_rdata, exp);
    rg_sel = 2'd3;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    rg_wr = 1'b1; rg_sel = sel; rg_wdata = d;
    @(negedge clk);
    rg_wr = 1'b0; rg_sel = 2'd3; rg_wdata = '0;
  endtask

  // one access cycle; paddr checked combinationally, exc/berr the cycle after
  task automatic acc(input string req, input logic fr, input logic [16:0] fa,
                     input logic dr, input logic dwe, input logic [16:0] da,
                     input logic [16:0] efp, input logic [16:0] edp,
                     input logic eexc, input logic eberr);
    @(negedge clk);
    if_req = fr; if_addr = fa; dm_req = dr; dm_we = dwe; dm_addr = da;
    #1;
    if (fr) chk({req, " fetch paddr"}, {15'b0, if_paddr}, {15'b0, efp});
    if (dr) chk({req, " data paddr"}, {15'b0, dm_paddr}, {15'b0, edp});
    @(negedge clk);
    if_req = 1'b0; dm_req = 1'b0; dm_we = 1'b0;
    chk({req, " miss_exc"}, {31'b0, miss_exc}, {31'b0, eexc});
    chk({req, " bus_err"}, {31'b0, bus_err}, {31'b0, eberr});
    @(negedge clk);
    chk({req, " miss_exc pulse end"}, {31'b0, miss_exc}, 32'h0);
    chk({req, " bus_err pulse end"}, {31'b0, bus_err}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 miss_exc", {31'b0, miss_exc}, 0);
    chk("R1 bus_err", {31'b0, bus_err}, 0);
    rd(2'd0, "R1 ctrl", 32'h0);
    rd(2'd2, "R1 pending", 32'h0);
  endtask

  task automatic t_passthrough;
    logic [16:0] outs [5] = '{17'h00000, 17'h01FFF, 17'h03FFF, 17'h0FFFF, 17'h18000};
    foreach (outs[i]) acc("R3 outside", 1'b1, outs[i], 1'b1, 1'b0, outs[i], outs[i], outs[i], 1'b0, 1'b0);
  endtask

  task automatic t_first_miss;
    acc("R4 fetch miss", 1'b1, 17'h12345, 1'b0, 1'b0, 17'h0, 17'h12345, 17'h0, 1'b1, 1'b0);
    rd(2'd2, "R4 pending set", 32'h1);
    rd(2'd1, "R8 fault fetch", 32'h8001_2345);
  endtask

  task automatic t_masked;
    acc("R5 masked miss", 1'b0, 17'h0, 1'b1, 1'b0, 17'h16000, 17'h0, 17'h16000, 1'b0, 1'b0);
    rd(2'd1, "R5 fault kept", 32'h8001_2345);
  endtask

  task automatic t_handler;
    wr(2'd0, 32'h3);                 // tag 1, valid
    rd(2'd0, "R7 ctrl readback", 32'h3);
    wr(2'd2, 32'h1);
    rd(2'd2, "R6 pending cleared", 32'h0);
    acc("R2 fetch hit", 1'b1, 17'h12345, 1'b0, 1'b0, 17'h0, xlate(17'h12345, 1, 1), 17'h0, 1'b0, 1'b0);
    chk("R2 fetch value", 32'h2345, {15'b0, xlate(17'h12345, 1, 1)});
    acc("R2 load page end", 1'b0, 17'h0, 1'b1, 1'b0, 17'h13FFF, 17'h0, 17'h03FFF, 1'b0, 1'b0);
    acc("R2 load page start", 1'b0, 17'h0, 1'b1, 1'b0, 17'h12000, 17'h0, 17'h02000, 1'b0, 1'b0);
    acc("R3 above window", 1'b1, 17'h18000, 1'b0, 1'b0, 17'h0, 17'h18000, 17'h0, 1'b0, 1'b0);
  endtask

  task automatic t_other_page;
    acc("R4 load miss last byte", 1'b0, 17'h0, 1'b1, 1'b0, 17'h17FFF, 17'h0, 17'h17FFF, 1'b1, 1'b0);
    rd(2'd1, "R8 fault load", 32'h0001_7FFF);
    wr(2'd2, 32'h1);
    rd(2'd2, "R6 clear again", 32'h0);
  endtask

  task automatic t_simul;
    acc("R8 dual miss", 1'b1, 17'h10010, 1'b1, 1'b0, 17'h14000, 17'h10010, 17'h14000, 1'b1, 1'b0);
    rd(2'd1, "R8 fetch wins", 32'h8001_0010);
    wr(2'd2, 32'h1);
  endtask

  task automatic t_write;
    acc("R9 write resident", 1'b0, 17'h0, 1'b1, 1'b1, 17'h12345, 17'h0, 17'h12345, 1'b0, 1'b1);
    acc("R9 write absent", 1'b0, 17'h0, 1'b1, 1'b1, 17'h10000, 17'h0, 17'h10000, 1'b0, 1'b1);
    acc("R9 write outside", 1'b0, 17'h0, 1'b1, 1'b1, 17'h00100, 17'h0, 17'h00100, 1'b0, 1'b0);
    rd(2'd2, "R9 pending untouched", 32'h0);
    rd(2'd0, "R9 ctrl untouched", 32'h3);
  endtask

  task automatic t_invalidate;
    wr(2'd0, 32'h2);                 // tag 1, not valid
    rd(2'd0, "R7 valid cleared", 32'h2);
    acc("R7 invalid misses", 1'b1, 17'h12345, 1'b0, 1'b0, 17'h0, 17'h12345, 17'h0, 1'b1, 1'b0);
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h7);                 // tag 3, valid
    acc("R7 tag 3 hit", 1'b1, 17'h16ABC, 1'b0, 1'b0, 17'h0, xlate(17'h16ABC, 1, 3), 17'h0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    if_req = 0; if_addr = '0; dm_req = 0; dm_we = 0; dm_addr = '0;
    rg_wr = 0; rg_sel = 2'd3; rg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_first_miss();
    t_masked();
    t_handler();
    t_other_page();
    t_simul();
    t_write();
    t_invalidate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule